// File: doc/BRIEF.md
# Brown-out reset sequencer

This block produces the internal reset for a small microcontroller core. Its inputs are a digital flag from an analog supply comparator, which is high while the supply is under the brown-out threshold, and a request line that gathers the other reset causes, such as the watchdog. An active-low power-on input clears the block asynchronously and leaves it holding reset.

A 2-bit configuration field selects how brown-out detection is enabled. Detection can be always off, controlled by a software bit, enabled only while the core is awake, or always on. The comparator flag first passes through a two-flop synchronizer. It then passes through a deglitch counter, so that only a low-supply condition lasting longer than `TBOR_CYC` clock cycles counts as a brown-out.

After any reset cause, reset stays asserted for as long as the supply is low. When the configured power-up timer is enabled, reset is then stretched by a further `PWRT_CYC` cycles. This count starts again from zero if the supply dips during it. A sticky flag records that a brown-out caused a reset, and software clears it.

Top module: `bor_seq`

## Requirements
- R1: With `bor_mode` = 2'b00, no low-supply condition of any length causes a reset while the core is running.
- R2: With `bor_mode` = 2'b01, a long low-supply condition causes a reset only when `sw_bor_en` is 1.
- R3: With `bor_mode` = 2'b10, a long low-supply condition causes a reset when `sleep` is 0 and does not when `sleep` is 1, whatever the value of `sw_bor_en`.
- R4: With detection enabled (`bor_mode` = 2'b11 always enables it), a low-supply pulse of `TBOR_CYC`/2 cycles causes no reset, and one of 3*`TBOR_CYC` cycles causes one.
- R5: Once reset is asserted, it stays asserted as long as `vlow` is 1, even after `rst_req` is released.
- R6: With `pwrt_n` = 0, reset is released between `PWRT_CYC` and `PWRT_CYC`+5 cycles after the supply recovers. With `pwrt_n` = 1, it is released within 5 cycles.
- R7: If `vlow` rises while the power-up timer is counting, reset stays asserted and a full `PWRT_CYC` count restarts after the supply recovers.
- R8: `bor_flag` goes to 1 when a brown-out resets the running core, stays at 1 until `flag_clr` is pulsed, and is 0 after a power-on.
- R9: `rst_req` = 1 asserts reset without setting `bor_flag`. After a power-on, `rst_out` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| rst_req | input | 1 | Other reset requests (watchdog, external pin), active high |
| vlow | input | 1 | Comparator flag: 1 while the supply is below the threshold |
| sleep | input | 1 | 1 while the core is in sleep |
| sw_bor_en | input | 1 | Software enable for brown-out detection, used in mode 01 |
| bor_mode | input | 2 | Enable mode: 00 off, 01 software, 10 awake only, 11 on |
| pwrt_n | input | 1 | Power-up timer enable, active low |
| flag_clr | input | 1 | Pulse that clears `bor_flag` |
| bor_flag | output | 1 | Sticky flag: the last reset was a brown-out |
| rst_out | output | 1 | Internal reset, active high |

## Verification
The hardest case to reach is a supply dip that lands partway through the power-up count. The dip must be short enough not to look like a fresh reset, yet it must interrupt a timer that is hidden from the ports. To get there, the bench first forces a brown-out and releases the supply. It waits about half of `PWRT_CYC` while reset is still high, then raises `vlow` for a few cycles. After that it measures the remaining reset length from the second recovery, so that a timer which only resumed counting would release reset far too early.

// File: rtl/bor_seq.sv
module bor_seq #(
  parameter int TBOR_CYC = 8,
  parameter int PWRT_CYC = 64
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       rst_req,
  input  logic       vlow,
  input  logic       sleep,
  input  logic       sw_bor_en,
  input  logic [1:0] bor_mode,
  input  logic       pwrt_n,
  input  logic       flag_clr,
  output logic       bor_flag,
  output logic       rst_out
);
  localparam int FW = $clog2(TBOR_CYC + 1);
  localparam int PW = $clog2(PWRT_CYC);

  typedef enum logic [1:0] {HOLD, TIMING, RUN} st_t;

  st_t st;
  logic [1:0] vsync;
  logic vlow_s, bor_en, bor_hit;
  logic [FW-1:0] flt;
  logic [PW-1:0] pcnt;

  assign vlow_s = vsync[1];

  always_comb begin
    case (bor_mode)
      2'b00:   bor_en = 1'b0;
      2'b01:   bor_en = sw_bor_en;
      2'b10:   bor_en = ~sleep;
      default: bor_en = 1'b1;
    endcase
  end

  assign bor_hit = vlow_s & bor_en & (flt == FW'(TBOR_CYC));
  assign rst_out = (st != RUN);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) vsync <= 2'b00;
    else        vsync <= {vsync[0], vlow};
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                        flt <= '0;
    else if (!(vlow_s && bor_en))      flt <= '0;
    else if (flt != FW'(TBOR_CYC))     flt <= flt + 1'b1;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      st   <= HOLD;
      pcnt <= '0;
    end else begin
      case (st)
        RUN: if (rst_req || bor_hit) st <= HOLD;
        HOLD: begin
          pcnt <= '0;
          if (!rst_req && !vlow_s) st <= pwrt_n ? RUN : TIMING;
        end
        TIMING: begin
          if (rst_req || vlow_s) begin
            st   <= HOLD;
            pcnt <= '0;
          end else if (pcnt == PW'(PWRT_CYC - 1)) begin
            st <= RUN;
          end else begin
            pcnt <= pcnt + 1'b1;
          end
        end
        default: st <= HOLD;
      endcase
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                        bor_flag <= 1'b0;
    else if (st == RUN && bor_hit)     bor_flag <= 1'b1;
    else if (flag_clr)                 bor_flag <= 1'b0;
  end

  AST_NO_BOR_WHEN_OFF: assert property (@(posedge clk) disable iff (!por_n)
    (!bor_en && !rst_req && !rst_out) |=> !rst_out); // R1

  AST_SHORT_DIP_IGNORED: assert property (@(posedge clk) disable iff (!por_n)
    ($rose(vlow_s) && !rst_req && !rst_out) |=> !rst_out); // R4

  AST_HOLD_WHILE_LOW: assert property (@(posedge clk) disable iff (!por_n)
    (vlow_s && rst_out) |=> rst_out); // R5

  AST_TIMER_RESTART: assert property (@(posedge clk) disable iff (!por_n)
    (st == TIMING && vlow_s) |=> (st == HOLD)); // R7

  AST_FLAG_ON_BOR: assert property (@(posedge clk) disable iff (!por_n)
    (bor_hit && !rst_out) |=> (bor_flag && rst_out)); // R8

  AST_REQ_RESETS: assert property (@(posedge clk) disable iff (!por_n)
    rst_req |=> rst_out); // R9
endmodule

// File: tb/sim_bor_seq.sv
module sim_bor_seq;
  localparam int TB = 8;
  localparam int PW = 64;

  logic clk = 0, por_n = 0, rst_req = 0, vlow = 0, sleep = 0, sw_bor_en = 0;
  logic [1:0] bor_mode = 2'b11;
  logic pwrt_n = 0, flag_clr = 0;
  logic bor_flag, rst_out;
  int n_chk = 0, n_bad = 0;
  bit saw_rst = 0;

  always #4 clk = ~clk;

  bor_seq #(.TBOR_CYC(TB), .PWRT_CYC(PW)) u0 (
    .clk(clk), .por_n(por_n), .rst_req(rst_req), .vlow(vlow), .sleep(sleep),
    .sw_bor_en(sw_bor_en), .bor_mode(bor_mode), .pwrt_n(pwrt_n),
    .flag_clr(flag_clr), .bor_flag(bor_flag), .rst_out(rst_out));

  always @(negedge clk) if (rst_out) saw_rst = 1;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_rng(input string req, input int act, input int lo, input int hi);
    n_chk++;
    if (act < lo || act > hi) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rel_len(output int n);
    n = 0;
    while (rst_out && n < 4 * PW) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic boot();
    int n;
    @(negedge clk);
    por_n = 0; vlow = 0; rst_req = 0; pwrt_n = 1; flag_clr = 0;
    cyc(2);
    por_n = 1;
    rel_len(n);
    cyc(2);
  endtask

  task automatic dip(input int n, output bit got);
    @(negedge clk);
    saw_rst = 0;
    vlow = 1;
    cyc(n);
    vlow = 0;
    cyc(4);
    got = saw_rst;
    while (rst_out) @(negedge clk);
    cyc(2);
  endtask

  task automatic t_por();
    int n;
    @(negedge clk);
    por_n = 0; pwrt_n = 0; bor_mode = 2'b11;
    cyc(2);
    chk("R9 reset after power-on", rst_out, 1);
    chk("R8 flag clear after power-on", bor_flag, 0);
    por_n = 1;
    rel_len(n);
    chk_rng("R6 power-up stretch", n, PW, PW + 5);
  endtask

  task automatic t_filter();
    bit g;
    boot(); bor_mode = 2'b11;
    dip(TB / 2, g);
    chk("R4 short dip ignored", g, 0);
    chk("R4 no flag on short dip", bor_flag, 0);
    dip(3 * TB, g);
    chk("R4 long dip resets", g, 1);
    chk("R8 flag set by brown-out", bor_flag, 1);
    cyc(5);
    chk("R8 flag sticky", bor_flag, 1);
    flag_clr = 1; cyc(1); flag_clr = 0; cyc(1);
    chk("R8 flag cleared", bor_flag, 0);
  endtask

  task automatic t_modes();
    bit g;
    boot();
    bor_mode = 2'b00; sw_bor_en = 1;
    dip(3 * TB, g); chk("R1 mode 00 ignores dip", g, 0);
    bor_mode = 2'b01; sw_bor_en = 0;
    dip(3 * TB, g); chk("R2 mode 01 sw off", g, 0);
    sw_bor_en = 1;
    dip(3 * TB, g); chk("R2 mode 01 sw on", g, 1);
    bor_mode = 2'b10; sleep = 1; sw_bor_en = 1;
    dip(3 * TB, g); chk("R3 mode 10 asleep", g, 0);
    sleep = 0; sw_bor_en = 0;
    dip(3 * TB, g); chk("R3 mode 10 awake sw off", g, 1);
    bor_mode = 2'b11;
  endtask

  task automatic t_hold();
    int n;
    boot(); bor_mode = 2'b00; pwrt_n = 1;
    @(negedge clk);
    vlow = 1; rst_req = 1;
    cyc(3);
    rst_req = 0;
    cyc(20);
    chk("R5 reset held while low", rst_out, 1);
    chk("R9 request sets no flag", bor_flag, 0);
    vlow = 0;
    rel_len(n);
    chk_rng("R6 no timer release", n, 0, 5);
    chk("R5 released after recovery", rst_out, 0);
    bor_mode = 2'b11;
  endtask

  task automatic t_restart();
    int n;
    boot(); bor_mode = 2'b11; pwrt_n = 0;
    @(negedge clk);
    vlow = 1; cyc(3 * TB); vlow = 0;
    cyc(PW / 2);
    chk("R7 still in timer", rst_out, 1);
    vlow = 1; cyc(3); vlow = 0;
    rel_len(n);
    chk_rng("R7 full count after dip", n, PW, PW + 5);
  endtask

  initial begin
    t_por();
    t_filter();
    t_modes();
    t_hold();
    t_restart();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule